// File: doc/BRIEF.md
# Two-Wide Renaming Core with In-Order Retirement

This block is a compact out-of-order execution engine for a stream of register-to-register add and multiply operations. Each cycle it can take in two decoded operations, give each result a private rename buffer, and track source operands through a rename map. That way only true data dependences hold an operation back. Operations wait in an eight-entry window. Each one goes to a one-cycle adder or a two-stage pipelined multiplier once its operands are present. The oldest ready operation wins each unit.

Results finish out of order but become architectural strictly in program order. One operation retires per cycle from the head of the window. Retirement copies the buffered result into the architectural register file, but only when no younger in-flight operation has claimed the same destination. A read port exposes the architectural registers.

Top module: `ooo_core`

## Requirements
- R1: Slot 0 is accepted (`in_ack_o[0]`) when slot 0 is valid and at least one rename buffer is free. Slot 1 is accepted only when slot 0 is accepted in the same cycle and at least two buffers are free. Slot 0 is older in program order.
- R2: Each retired result, and the final architectural state, equal sequential execution in program order (op 0 = add, op 1 = multiply, both modulo 2^DATA_W), whatever write-after-read or write-after-write pairs the stream contains.
- R3: With an empty window and ready operands, an add accepted at clock edge E shows `ret_valid_o` in the cycle after edge E+2, and a multiply in the cycle after edge E+3.
- R4: Retirement follows acceptance order. An add that completes before an older multiply retires one cycle after that multiply.
- R5: A result wakes its consumers in the cycle it completes. A dependent add accepted together with its producing add retires two cycles after the producer.
- R6: When several ready operations need the same unit, the oldest is issued first. Two independent adds accepted together retire in consecutive cycles, the first at the R3 latency.
- R7: A retiring operation whose destination has a younger accepted writer reports `ret_wr_o` = 0 and leaves the register unchanged. Only the last writer's value remains.
- R8: A retirement with `ret_wr_o` = 1 writes `ret_data_o` into register `ret_rd_o`, readable on `rf_data_o` from the next cycle.
- R9: With all eight buffers in use no slot is accepted. With one free only slot 0 is accepted.
- R10: After reset, register i reads value i, nothing retires, and two valid slots are both accepted.
- R11: The multiplier takes one new operation per cycle. Two independent multiplies accepted together retire in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 2 | Slot valid, bit 0 is the older slot |
| in_op_i | input | 2 | Per slot: 0 add, 1 multiply |
| in_rd_i | input | 2*REG_W | Destination registers, slot 0 in the low bits |
| in_rs1_i | input | 2*REG_W | First source registers |
| in_rs2_i | input | 2*REG_W | Second source registers |
| in_ack_o | output | 2 | Slot accepted this cycle |
| ret_valid_o | output | 1 | An operation retires this cycle |
| ret_rd_o | output | REG_W | Destination of the retiring operation |
| ret_data_o | output | DATA_W | Result of the retiring operation |
| ret_wr_o | output | 1 | Retirement updates the architectural register |
| rf_addr_i | input | REG_W | Architectural register read address |
| rf_data_o | output | DATA_W | Architectural register read data |

## Verification
A stale rename map entry or a missed wakeup shows up on the very next retirement that depends on it. Either `ret_data_o` disagrees with the sequential model, or the retire never arrives and the window fills until acceptance stops. A wrong head pointer or a lost completion shows as retirements out of program order or one cycle late, so exact retire cycles are compared for the directed latency cases. A wrong map-clear decision surfaces as a wrong `ret_wr_o` at once, and it also shows as a wrong register value when the bench reads the registers after draining.

// File: rtl/ooo_core_pkg.sv
package ooo_core_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} op_e;
endpackage

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NREG  = 8,
  parameter int TAG_W = 3,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_en_i,
  input  logic [REG_W-1:0]            clr_reg_i,
  input  logic [TAG_W-1:0]            clr_tag_i,
  input  logic [1:0]                  wr_en_i,
  input  logic [1:0][REG_W-1:0]       wr_reg_i,
  input  logic [1:0][TAG_W-1:0]       wr_tag_i,
  output logic [NREG-1:0]             busy_o,
  output logic [NREG-1:0][TAG_W-1:0]  tag_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_o[g] <= 1'b0;
        tag_o[g]  <= '0;
      end else begin
        // clear only if the retiring buffer is still the newest mapping
        if (clr_en_i && clr_reg_i == REG_W'(g) && busy_o[g] && tag_o[g] == clr_tag_i)
          busy_o[g] <= 1'b0;
        // younger slot last so it wins a same-register pair
        for (int s = 0; s < 2; s++) begin
          if (wr_en_i[s] && wr_reg_i[s] == REG_W'(g)) begin
            busy_o[g] <= 1'b1;
            tag_o[g]  <= wr_tag_i[s];
          end
        end
      end
    end
  end
endmodule

// File: rtl/age_picker.sv
module age_picker #(
  parameter int N = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] head_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [IDX_W-1:0] pos;
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    pos   = '0;
    for (int k = 0; k < N; k++) begin
      pos = head_i + k[IDX_W-1:0];
      if (!any_o && req_i[pos]) begin
        any_o      = 1'b1;
        idx_o      = pos;
        gnt_o[pos] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/exec_units.sv
module exec_units #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_go_i,
  input  logic [TAG_W-1:0]  add_tag_i,
  input  logic [DATA_W-1:0] add_a_i,
  input  logic [DATA_W-1:0] add_b_i,
  input  logic              mul_go_i,
  input  logic [TAG_W-1:0]  mul_tag_i,
  input  logic [DATA_W-1:0] mul_a_i,
  input  logic [DATA_W-1:0] mul_b_i,
  output logic              add_v_o,
  output logic [TAG_W-1:0]  add_tag_o,
  output logic [DATA_W-1:0] add_res_o,
  output logic              mul_v_o,
  output logic [TAG_W-1:0]  mul_tag_o,
  output logic [DATA_W-1:0] mul_res_o
);
  logic              m1_v;
  logic [TAG_W-1:0]  m1_tag;
  logic [DATA_W-1:0] m1_a, m1_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      add_v_o   <= 1'b0;
      add_tag_o <= '0;
      add_res_o <= '0;
      m1_v      <= 1'b0;
      m1_tag    <= '0;
      m1_a      <= '0;
      m1_b      <= '0;
      mul_v_o   <= 1'b0;
      mul_tag_o <= '0;
      mul_res_o <= '0;
    end else begin
      add_v_o   <= add_go_i;
      add_tag_o <= add_tag_i;
      add_res_o <= add_a_i + add_b_i;
      m1_v      <= mul_go_i;
      m1_tag    <= mul_tag_i;
      m1_a      <= mul_a_i;
      m1_b      <= mul_b_i;
      mul_v_o   <= m1_v;
      mul_tag_o <= m1_tag;
      mul_res_o <= m1_a * m1_b;
    end
  end
endmodule

// File: rtl/arch_regfile.sv
module arch_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 16,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [REG_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_o[i] <= DATA_W'(i);
    end else if (we_i) begin
      regs_o[waddr_i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ooo_core.sv
module ooo_core #(
  parameter int NREG   = 8,
  parameter int NBUF   = 8,
  parameter int DATA_W = 16,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           in_valid_i,
  input  logic [1:0]           in_op_i,
  input  logic [2*REG_W-1:0]   in_rd_i,
  input  logic [2*REG_W-1:0]   in_rs1_i,
  input  logic [2*REG_W-1:0]   in_rs2_i,
  output logic [1:0]           in_ack_o,
  output logic                 ret_valid_o,
  output logic [REG_W-1:0]     ret_rd_o,
  output logic [DATA_W-1:0]    ret_data_o,
  output logic                 ret_wr_o,
  input  logic [REG_W-1:0]     rf_addr_i,
  output logic [DATA_W-1:0]    rf_data_o
);
  import ooo_core_pkg::*;

  localparam int TAG_W = $clog2(NBUF);
  localparam int CNT_W = $clog2(NBUF + 1);

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  logic [NBUF-1:0]   v_q, iss_q, done_q, op_q;
  logic [REG_W-1:0]  rd_q   [NBUF];
  logic [1:0]        srdy_q [NBUF];
  logic [TAG_W-1:0]  stag_q [NBUF][2];
  logic [DATA_W-1:0] sval_q [NBUF][2];
  logic [DATA_W-1:0] res_q  [NBUF];

  logic [NREG-1:0]             map_busy;
  logic [NREG-1:0][TAG_W-1:0]  map_tag;
  logic [NREG-1:0][DATA_W-1:0] rf_regs;

  logic              add_v, mul_v;
  logic [TAG_W-1:0]  add_tag, mul_tag;
  logic [DATA_W-1:0] add_res, mul_res;

  // slot decode
  logic [1:0][REG_W-1:0] s_rd;
  logic [REG_W-1:0]      s_rs [2][2];
  logic [1:0][TAG_W-1:0] s_tag;
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      s_rd[s]    = in_rd_i[s*REG_W +: REG_W];
      s_rs[s][0] = in_rs1_i[s*REG_W +: REG_W];
      s_rs[s][1] = in_rs2_i[s*REG_W +: REG_W];
    end
    s_tag[0] = tail_q;
    s_tag[1] = tail_q + TAG_W'(1);
  end

  assign in_ack_o[0] = in_valid_i[0] && (cnt_q < CNT_W'(NBUF));
  assign in_ack_o[1] = in_valid_i[1] && in_ack_o[0] && (cnt_q < CNT_W'(NBUF - 1));

  // operand lookup for both slots
  logic [1:0]        lk_rdy [2];
  logic [TAG_W-1:0]  lk_tag [2][2];
  logic [DATA_W-1:0] lk_val [2][2];
  always_comb begin
    logic [REG_W-1:0] r;
    logic [TAG_W-1:0] t;
    for (int s = 0; s < 2; s++) begin
      for (int j = 0; j < 2; j++) begin
        r = s_rs[s][j];
        t = map_tag[r];
        lk_rdy[s][j] = 1'b1;
        lk_tag[s][j] = t;
        lk_val[s][j] = rf_regs[r];
        if (s == 1 && in_ack_o[0] && r == s_rd[0]) begin
          lk_rdy[s][j] = 1'b0;
          lk_tag[s][j] = s_tag[0];
        end else if (map_busy[r]) begin
          if (done_q[t])                 lk_val[s][j] = res_q[t];
          else if (add_v && add_tag == t) lk_val[s][j] = add_res;
          else if (mul_v && mul_tag == t) lk_val[s][j] = mul_res;
          else                            lk_rdy[s][j] = 1'b0;
        end
      end
    end
  end

  // select
  logic [NBUF-1:0]  rdy_vec, add_gnt, mul_gnt;
  logic [TAG_W-1:0] add_idx, mul_idx;
  logic             add_go, mul_go;
  always_comb begin
    for (int i = 0; i < NBUF; i++) rdy_vec[i] = v_q[i] & ~iss_q[i] & (&srdy_q[i]);
  end

  age_picker #(.N(NBUF)) i_add_pick (
    .req_i(rdy_vec & ~op_q), .head_i(head_q), .gnt_o(add_gnt), .idx_o(add_idx), .any_o(add_go));
  age_picker #(.N(NBUF)) i_mul_pick (
    .req_i(rdy_vec & op_q), .head_i(head_q), .gnt_o(mul_gnt), .idx_o(mul_idx), .any_o(mul_go));

  exec_units #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_exec (
    .clk_i, .rst_ni,
    .add_go_i(add_go), .add_tag_i(add_idx), .add_a_i(sval_q[add_idx][0]), .add_b_i(sval_q[add_idx][1]),
    .mul_go_i(mul_go), .mul_tag_i(mul_idx), .mul_a_i(sval_q[mul_idx][0]), .mul_b_i(sval_q[mul_idx][1]),
    .add_v_o(add_v), .add_tag_o(add_tag), .add_res_o(add_res),
    .mul_v_o(mul_v), .mul_tag_o(mul_tag), .mul_res_o(mul_res));

  // retire
  assign ret_valid_o = v_q[head_q] & done_q[head_q];
  assign ret_rd_o    = rd_q[head_q];
  assign ret_data_o  = res_q[head_q];
  assign ret_wr_o    = ret_valid_o && map_busy[ret_rd_o] && map_tag[ret_rd_o] == head_q;

  rename_map #(.NREG(NREG), .TAG_W(TAG_W)) i_map (
    .clk_i, .rst_ni,
    .clr_en_i(ret_valid_o), .clr_reg_i(ret_rd_o), .clr_tag_i(head_q),
    .wr_en_i(in_ack_o), .wr_reg_i(s_rd), .wr_tag_i(s_tag),
    .busy_o(map_busy), .tag_o(map_tag));

  arch_regfile #(.NREG(NREG), .DATA_W(DATA_W)) i_rf (
    .clk_i, .rst_ni, .we_i(ret_wr_o), .waddr_i(ret_rd_o), .wdata_i(ret_data_o), .regs_o(rf_regs));

  assign rf_data_o = rf_regs[rf_addr_i];

  // window / rename buffers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0; iss_q <= '0; done_q <= '0; op_q <= '0;
      for (int i = 0; i < NBUF; i++) begin
        rd_q[i]   <= '0;
        srdy_q[i] <= '0;
        res_q[i]  <= '0;
        for (int j = 0; j < 2; j++) begin
          stag_q[i][j] <= '0;
          sval_q[i][j] <= '0;
        end
      end
    end else begin
      for (int i = 0; i < NBUF; i++) begin
        if (ret_valid_o && head_q == TAG_W'(i)) v_q[i] <= 1'b0;
        for (int j = 0; j < 2; j++) begin
          if (v_q[i] && !srdy_q[i][j]) begin
            if (add_v && add_tag == stag_q[i][j]) begin
              srdy_q[i][j] <= 1'b1;
              sval_q[i][j] <= add_res;
            end else if (mul_v && mul_tag == stag_q[i][j]) begin
              srdy_q[i][j] <= 1'b1;
              sval_q[i][j] <= mul_res;
            end
          end
        end
        if (add_gnt[i] || mul_gnt[i]) iss_q[i] <= 1'b1;
        if (add_v && add_tag == TAG_W'(i)) begin
          done_q[i] <= 1'b1;
          res_q[i]  <= add_res;
        end
        if (mul_v && mul_tag == TAG_W'(i)) begin
          done_q[i] <= 1'b1;
          res_q[i]  <= mul_res;
        end
        for (int s = 0; s < 2; s++) begin
          if (in_ack_o[s] && s_tag[s] == TAG_W'(i)) begin
            v_q[i]    <= 1'b1;
            iss_q[i]  <= 1'b0;
            done_q[i] <= 1'b0;
            op_q[i]   <= in_op_i[s];
            rd_q[i]   <= s_rd[s];
            srdy_q[i] <= lk_rdy[s];
            for (int j = 0; j < 2; j++) begin
              stag_q[i][j] <= lk_tag[s][j];
              sval_q[i][j] <= lk_val[s][j];
            end
          end
        end
      end
    end
  end

  logic [CNT_W-1:0] n_acc;
  assign n_acc = CNT_W'(in_ack_o[0]) + CNT_W'(in_ack_o[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + TAG_W'(ret_valid_o);
      tail_q <= tail_q + TAG_W'(n_acc);
      cnt_q  <= cnt_q + n_acc - CNT_W'(ret_valid_o);
    end
  end
endmodule

// File: rtl/ooo_core_chk.sv
module ooo_core_chk #(
  parameter int NREG   = 8,
  parameter int NBUF   = 8,
  parameter int DATA_W = 16,
  localparam int REG_W = $clog2(NREG),
  localparam int CNT_W = $clog2(NBUF + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  in_ack_i,
  input logic [CNT_W-1:0]            cnt_i,
  input logic [NBUF-1:0]             add_gnt_i,
  input logic [NBUF-1:0]             mul_gnt_i,
  input logic                        ret_valid_i,
  input logic                        ret_wr_i,
  input logic [REG_W-1:0]            ret_rd_i,
  input logic [DATA_W-1:0]           ret_data_i,
  input logic [NREG-1:0][DATA_W-1:0] regs_i
);
  p_slot_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ack_i[1] |-> in_ack_i[0]);

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(NBUF));

  p_full_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(NBUF)) |-> (in_ack_i == 2'b00));

  p_one_add_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(add_gnt_i));

  p_one_mul_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mul_gnt_i));

  p_rf_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && ret_wr_i) |=> regs_i[$past(ret_rd_i)] == $past(ret_data_i));

  p_empty_no_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !ret_valid_i);
endmodule

bind ooo_core ooo_core_chk #(.NREG(NREG), .NBUF(NBUF), .DATA_W(DATA_W)) i_ooo_core_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ack_i(in_ack_o), .cnt_i(cnt_q),
  .add_gnt_i(add_gnt), .mul_gnt_i(mul_gnt), .ret_valid_i(ret_valid_o), .ret_wr_i(ret_wr_o),
  .ret_rd_i(ret_rd_o), .ret_data_i(ret_data_o), .regs_i(rf_regs));

// File: tb/test_ooo_core.sv
module test_ooo_core;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  in_valid = '0, in_op = '0;
  logic [5:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [1:0]  in_ack;
  logic        ret_valid, ret_wr;
  logic [2:0]  ret_rd;
  logic [15:0] ret_data;
  logic [2:0]  rf_addr = '0;
  logic [15:0] rf_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ooo_core i_ooo_core (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_op_i(in_op),
    .in_rd_i(in_rd), .in_rs1_i(in_rs1), .in_rs2_i(in_rs2), .in_ack_o(in_ack),
    .ret_valid_o(ret_valid), .ret_rd_o(ret_rd), .ret_data_o(ret_data), .ret_wr_o(ret_wr),
    .rf_addr_i(rf_addr), .rf_data_o(rf_data));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [15:0] mreg [8];
  logic [2:0]  q_rd  [QD];
  logic [15:0] q_res [QD];
  int          q_acc [QD];
  int          lat   [QD];
  logic        o_wr  [QD];
  int rp = 0, wp = 0;
  logic [1:0] last_ack;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] calc(input logic op, input logic [15:0] a, input logic [15:0] b);
    return op ? 16'(a * b) : 16'(a + b);
  endfunction

  task automatic step(input logic [1:0] v, input logic [1:0] op,
                      input logic [2:0] d0, input logic [2:0] a0, input logic [2:0] b0,
                      input logic [2:0] d1, input logic [2:0] a1, input logic [2:0] b1);
    @(negedge clk);
    if (ret_valid) begin
      if (rp == wp) chk(0, "R4 spurious retire", 1, 0);
      else begin
        bit ew = 1;
        for (int k = rp + 1; k < wp; k++) if (q_rd[k] == ret_rd) ew = 0;
        chk(ret_rd == q_rd[rp], "R4 retire order rd", ret_rd, q_rd[rp]);
        chk(ret_data == q_res[rp], "R2 retire data", ret_data, q_res[rp]);
        chk(ret_wr == ew, "R7 retire write flag", ret_wr, ew);
        lat[rp]  = cyc - q_acc[rp];
        o_wr[rp] = ret_wr;
        rp++;
      end
    end
    in_valid = v; in_op = op;
    in_rd = {d1, d0}; in_rs1 = {a1, a0}; in_rs2 = {b1, b0};
    #1;
    last_ack = in_ack;
    if (in_ack[0]) begin
      q_res[wp] = calc(op[0], mreg[a0], mreg[b0]); mreg[d0] = q_res[wp];
      q_rd[wp] = d0; q_acc[wp] = cyc; wp++;
    end
    if (in_ack[1]) begin
      q_res[wp] = calc(op[1], mreg[a1], mreg[b1]); mreg[d1] = q_res[wp];
      q_rd[wp] = d1; q_acc[wp] = cyc; wp++;
    end
  endtask

  task automatic idle();
    step(2'b00, 2'b00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain_and_compare(input string req);
    while (rp != wp) idle();
    idle(); idle();
    for (int r = 0; r < 8; r++) begin
      rf_addr = 3'(r);
      #1;
      chk(rf_data == mreg[r], req, rf_data, mreg[r]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int id;
    void'($urandom(32'h5eed));
    for (int r = 0; r < 8; r++) mreg[r] = 16'(r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(ret_valid == 1'b0, "R10 no retire after reset", ret_valid, 0);
    for (int r = 0; r < 8; r++) begin
      rf_addr = 3'(r);
      #1;
      chk(rf_data == 16'(r), "R10 reset register value", rf_data, r);
    end
    in_valid = 2'b11; #1;
    chk(in_ack == 2'b11, "R10 both slots accepted when empty", in_ack, 3);
    in_valid = 2'b10; #1;
    chk(in_ack == 2'b00, "R1 slot1 alone not accepted", in_ack, 0);
    in_valid = 2'b00;

    // R3 add latency
    id = wp; step(2'b01, 2'b00, 1, 2, 3, 0, 0, 0); drain_and_compare("R8 regs after add");
    chk(lat[id] == 3, "R3 add latency", lat[id], 3);
    // R3 multiply latency
    id = wp; step(2'b01, 2'b01, 2, 3, 4, 0, 0, 0); drain_and_compare("R8 regs after mul");
    chk(lat[id] == 4, "R3 mul latency", lat[id], 4);
    // R6 two independent adds, oldest first
    id = wp; step(2'b11, 2'b00, 3, 1, 1, 4, 2, 2); drain_and_compare("R8 regs after add pair");
    chk(lat[id] == 3, "R6 older add first", lat[id], 3);
    chk(lat[id+1] == 4, "R6 younger add next", lat[id+1], 4);
    // R5 dependent add wakeup
    id = wp; step(2'b11, 2'b00, 5, 1, 2, 6, 5, 5); drain_and_compare("R5 regs after chain");
    chk(lat[id] == 3, "R5 producer latency", lat[id], 3);
    chk(lat[id+1] == 5, "R5 dependent latency", lat[id+1], 5);
    // R4 add behind older multiply
    id = wp; step(2'b11, 2'b01, 7, 1, 2, 0, 3, 4); drain_and_compare("R4 regs after mul/add");
    chk(lat[id] == 4, "R4 older mul latency", lat[id], 4);
    chk(lat[id+1] == 5, "R4 younger add waits", lat[id+1], 5);
    // R11 pipelined multiplier
    id = wp; step(2'b11, 2'b11, 1, 2, 2, 2, 3, 3); drain_and_compare("R11 regs after mul pair");
    chk(lat[id] == 4, "R11 first mul", lat[id], 4);
    chk(lat[id+1] == 5, "R11 second mul", lat[id+1], 5);
    // R7 write-after-write: only last writer visible
    id = wp; step(2'b11, 2'b10, 4, 1, 2, 4, 3, 3); drain_and_compare("R7 regs after WAW");
    chk(o_wr[id] == 1'b0, "R7 overwritten add no write", o_wr[id], 0);
    chk(o_wr[id+1] == 1'b1, "R7 last writer writes", o_wr[id+1], 1);
    // R2 write-after-read in one pair
    step(2'b11, 2'b00, 6, 4, 5, 4, 1, 1); drain_and_compare("R2 regs after WAR");
    // R9 one buffer left
    for (int c = 0; c < 3; c++) step(2'b11, 2'b11, 1, 1, 1, 1, 1, 1);
    step(2'b01, 2'b11, 1, 1, 1, 0, 0, 0);
    step(2'b11, 2'b11, 2, 1, 1, 3, 2, 2);
    chk(last_ack == 2'b01, "R9 one free buffer", last_ack, 1);
    drain_and_compare("R9 regs after partial fill");
    // R9 full
    for (int c = 0; c < 4; c++) step(2'b11, 2'b11, 1, 1, 1, 1, 1, 1);
    step(2'b11, 2'b00, 2, 2, 2, 3, 3, 3);
    chk(last_ack == 2'b00, "R9 full stall", last_ack, 0);
    drain_and_compare("R9 regs after full");

    // random mix
    for (int c = 0; c < 400; c++) begin
      logic [1:0] v, op;
      v  = 2'($urandom_range(0, 3));
      op = 2'($urandom_range(0, 3));
      step(v, op, 3'($urandom), 3'($urandom), 3'($urandom),
           3'($urandom), 3'($urandom), 3'($urandom));
    end
    drain_and_compare("R2 regs after random");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule